// File: doc/BRIEF.md
# PWM Output Carrier Chopper

This block takes a slow, level-style digital drive signal and turns it into a train of high-frequency pulses, so that the signal can cross a small pulse transformer to a gate driver. Each time the drive signal goes high, the block first emits one wide pulse. That pulse charges the gate through the transformer. The block then switches to a carrier with a programmable rate and mark ratio, and keeps it running until the drive signal falls.

Three configuration fields set the behaviour: the width of the opening pulse, the carrier duty in eighths, and the carrier period in steps of 16 clocks. The fields can be loaded only while chopping is switched off. With chopping off, the drive signal passes through with one register of delay. The output is always registered, so every input edge reaches the output one clock later.

Top module: `pwm_chopper`

## Requirements
- R1: While `rst` is high, `sig_out` is low on every clock and the three configuration fields return to zero. With zero fields, the opening pulse lasts 16 clocks and no carrier follows it.
- R2: While `chop_en` is low, `sig_out` equals the value `sig_in` had on the previous clock.
- R3: With `chop_en` high, after `sig_in` goes high the output stays high for (`cfg_start_w`+1)×16 consecutive clocks, counted from the first clock after the input edge.
- R4: Once the opening pulse ends, the carrier starts at the beginning of a period and repeats every 16×(`cfg_freq`+1) clocks.
- R5: Within each carrier period, `sig_out` is high for the first `cfg_duty`×2×(`cfg_freq`+1) clocks and low for the rest, while `sig_in` stays high.
- R6: With `cfg_duty` equal to 0, only the opening pulse appears, and `sig_out` then stays low until the next input rise.
- R7: A write (`cfg_we` high) while `chop_en` is high is ignored. A write while `chop_en` is low takes effect from the next clock.
- R8: With `chop_en` high, a low `sig_in` drives `sig_out` low on the next clock, cutting short any opening pulse or carrier pulse in progress.
- R9: Raising `chop_en` while `sig_in` is already high starts a full opening pulse, just as an input rise would.
- R10: `sig_out` is registered: every change reaches the output exactly one clock after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| chop_en | input | 1 | Chopping on; also locks the configuration |
| sig_in | input | 1 | Drive signal to be modulated |
| cfg_we | input | 1 | Load strobe for the three configuration fields |
| cfg_start_w | input | 4 | Opening pulse width code, (code+1)×16 clocks |
| cfg_duty | input | 3 | Carrier high time in eighths of the period |
| cfg_freq | input | 4 | Carrier period code, 16×(code+1) clocks |
| sig_out | output | 1 | Chopped (or passed-through) output |

## Verification
The assertions assume that `rst`, `chop_en` and `sig_in` are synchronous to `clk` and free of glitches. Each value is held for whole clock cycles. The bench meets this by changing every input only on the falling clock edge. It toggles `chop_en` only at points where the configuration lock and the pass-through check are both well defined. It drives `cfg_we` both inside and outside the enabled window, so the lock property sees both cases.

// File: rtl/chop_pkg.sv
package chop_pkg;

    localparam int SPW_W      = 4;
    localparam int DUTY_W     = 3;
    localparam int FRQ_W      = 4;
    localparam int UNIT_CYC   = 16;
    localparam int NSLICE     = 1 << DUTY_W;
    localparam int SLICE_UNIT = UNIT_CYC / NSLICE;
    localparam int ST_CNT_W   = $clog2(UNIT_CYC * (1 << SPW_W)) + 1;
    localparam int CAR_CNT_W  = $clog2(UNIT_CYC * (1 << FRQ_W));

    typedef logic [ST_CNT_W-1:0]  st_cnt_t;
    typedef logic [CAR_CNT_W-1:0] car_cnt_t;

    typedef struct packed {
        logic [SPW_W-1:0]  spw;
        logic [DUTY_W-1:0] duty;
        logic [FRQ_W-1:0]  frq;
    } chop_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_CARRY,
        PH_BYPASS
    } chop_phase_e;

    function automatic st_cnt_t start_len(input logic [SPW_W-1:0] spw);
        return st_cnt_t'((32'(spw) + 1) * UNIT_CYC);
    endfunction

    function automatic car_cnt_t car_last(input logic [FRQ_W-1:0] frq);
        return car_cnt_t'((32'(frq) + 1) * UNIT_CYC - 1);
    endfunction

    function automatic car_cnt_t car_high(input logic [DUTY_W-1:0] duty,
                                          input logic [FRQ_W-1:0]  frq);
        return car_cnt_t'(32'(duty) * SLICE_UNIT * (32'(frq) + 1));
    endfunction

endpackage

// File: rtl/chop_cfg_lock.sv
module chop_cfg_lock
    import chop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lock,
    input  logic      we,
    input  chop_cfg_t wr_cfg,
    output chop_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we && !lock) begin
            cfg <= wr_cfg;
        end
    end

endmodule

// File: rtl/chop_start_timer.sv
module chop_start_timer
    import chop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  st_cnt_t len,
    output logic    active
);

    st_cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != len) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign active = (cnt < len);

endmodule

// File: rtl/chop_carrier.sv
module chop_carrier
    import chop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  car_cnt_t last,
    input  car_cnt_t high_len,
    output logic     carrier
);

    car_cnt_t pos;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos <= '0;
        end else if (pos == last) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    assign carrier = (pos < high_len);

endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
    import chop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chop_en,
    input  logic              sig_in,
    input  logic              cfg_we,
    input  logic [SPW_W-1:0]  cfg_start_w,
    input  logic [DUTY_W-1:0] cfg_duty,
    input  logic [FRQ_W-1:0]  cfg_freq,
    output logic              sig_out
);

    chop_cfg_t   wr_cfg;
    chop_cfg_t   cfg_q;
    chop_phase_e phase;
    logic        run;
    logic        in_start;
    logic        carrier;
    logic        out_d;

    assign wr_cfg = '{spw: cfg_start_w, duty: cfg_duty, frq: cfg_freq};
    assign run    = chop_en && sig_in;

    chop_cfg_lock u_cfg (
        .clk    (clk),
        .rst    (rst),
        .lock   (chop_en),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg    (cfg_q)
    );

    chop_start_timer u_start (
        .clk    (clk),
        .rst    (rst),
        .clr    (!run),
        .len    (start_len(cfg_q.spw)),
        .active (in_start)
    );

    chop_carrier u_car (
        .clk      (clk),
        .rst      (rst),
        .clr      (!run || in_start),
        .last     (car_last(cfg_q.frq)),
        .high_len (car_high(cfg_q.duty, cfg_q.frq)),
        .carrier  (carrier)
    );

    always_comb begin
        if (!chop_en)      phase = PH_BYPASS;
        else if (!sig_in)  phase = PH_IDLE;
        else if (in_start) phase = PH_START;
        else               phase = PH_CARRY;
    end

    always_comb begin
        case (phase)
            PH_BYPASS: out_d = sig_in;
            PH_START:  out_d = 1'b1;
            PH_CARRY:  out_d = carrier;
            default:   out_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sig_out <= 1'b0;
        else     sig_out <= out_d;
    end

endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk
    import chop_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      chop_en,
    input logic      sig_in,
    input logic      sig_out,
    input chop_cfg_t cfg_q,
    input logic      in_start
);

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !sig_out); // R1

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !chop_en |=> (sig_out == $past(sig_in))); // R2

    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        (chop_en && $rose(sig_in)) |=> sig_out); // R3

    AST_DUTY_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (chop_en && sig_in && cfg_q.duty == '0 && !in_start) |=> !sig_out); // R6

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        chop_en |=> $stable(cfg_q)); // R7

    AST_FALL_CUTS: assert property (@(posedge clk) disable iff (rst)
        (chop_en && !sig_in) |=> !sig_out); // R8

endmodule

bind pwm_chopper pwm_chopper_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .chop_en  (chop_en),
    .sig_in   (sig_in),
    .sig_out  (sig_out),
    .cfg_q    (cfg_q),
    .in_start (in_start)
);

// File: tb/pwm_chopper_bench.sv
`timescale 1ns/1ps
module pwm_chopper_bench;

    localparam real HALF    = 2.5;
    localparam int  MAX_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chop_en = 1'b0;
    logic       sig_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_start_w = '0;
    logic [2:0] cfg_duty = '0;
    logic [3:0] cfg_freq = '0;
    logic       sig_out;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int         k = 0;
    logic [3:0] m_s = '0;
    logic [2:0] m_d = '0;
    logic [3:0] m_f = '0;
    logic       exp_out = 1'b0;

    always #(HALF) clk = ~clk;

    pwm_chopper u_pwm_chopper (
        .clk         (clk),
        .rst         (rst),
        .chop_en     (chop_en),
        .sig_in      (sig_in),
        .cfg_we      (cfg_we),
        .cfg_start_w (cfg_start_w),
        .cfg_duty    (cfg_duty),
        .cfg_freq    (cfg_freq),
        .sig_out     (sig_out)
    );

    always @(posedge clk) begin
        int plen, per, hi;
        plen = (int'(m_s) + 1) * 16;
        per  = (int'(m_f) + 1) * 16;
        hi   = int'(m_d) * 2 * (int'(m_f) + 1);
        if (rst) begin
            exp_out = 1'b0;
            k = 0;
            m_s = '0; m_d = '0; m_f = '0;
        end else begin
            if (!chop_en)        exp_out = sig_in;
            else if (!sig_in)    exp_out = 1'b0;
            else if (k < plen)   exp_out = 1'b1;
            else                 exp_out = (((k - plen) % per) < hi);
            k = (chop_en && sig_in) ? k + 1 : 0;
            if (cfg_we && !chop_en) begin
                m_s = cfg_start_w; m_d = cfg_duty; m_f = cfg_freq;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            n_chk++;
            if (sig_out !== exp_out) begin
                n_fail++;
                $display("FAIL %s at %0t: sig_out=%b expected=%b", cur_req, $time, sig_out, exp_out);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [3:0] s, input logic [2:0] d, input logic [3:0] f);
        cfg_start_w = s; cfg_duty = d; cfg_freq = f; cfg_we = 1'b1;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        @(posedge clk);
        @(negedge clk);
        chk_on = 1'b1;
        cur_req = "R1";
        cyc(4);
        rst = 1'b0;
        cyc(3);
        // zero configuration: 16-clock opening pulse, nothing after
        chop_en = 1'b1; cyc(2);
        sig_in = 1'b1;  cyc(40);
        sig_in = 1'b0;  cyc(4);
        chop_en = 1'b0;

        cur_req = "R2";
        for (int i = 0; i < 12; i++) begin
            sig_in = i[0] ^ i[2]; cyc(1 + (i % 3));
        end
        cur_req = "R10";
        sig_in = 1'b1; cyc(1); sig_in = 1'b0; cyc(1); sig_in = 1'b1; cyc(3); sig_in = 1'b0; cyc(2);

        cur_req = "R3";
        write_cfg(4'd2, 3'd3, 4'd1);
        chop_en = 1'b1; cyc(1);
        sig_in = 1'b1; cyc(50);
        cur_req = "R4/R5";
        cyc(120);
        sig_in = 1'b0; cyc(3);
        chop_en = 1'b0; cyc(1);

        cur_req = "R3";
        write_cfg(4'd15, 3'd7, 4'd15);
        chop_en = 1'b1; cyc(1);
        sig_in = 1'b1; cyc(260);
        cur_req = "R5";
        cyc(560);
        sig_in = 1'b0; cyc(3);
        chop_en = 1'b0; cyc(1);

        cur_req = "R6";
        write_cfg(4'd1, 3'd0, 4'd3);
        chop_en = 1'b1; cyc(1);
        sig_in = 1'b1; cyc(200);
        sig_in = 1'b0; cyc(3);
        chop_en = 1'b0; cyc(1);

        cur_req = "R8";
        write_cfg(4'd3, 3'd4, 4'd2);
        chop_en = 1'b1; cyc(1);
        sig_in = 1'b1; cyc(20);
        sig_in = 1'b0; cyc(3);
        sig_in = 1'b1; cyc(80);
        sig_in = 1'b0; cyc(4);
        chop_en = 1'b0; cyc(1);

        cur_req = "R9";
        sig_in = 1'b1; cyc(5);
        chop_en = 1'b1; cyc(100);
        chop_en = 1'b0; cyc(2);
        sig_in = 1'b0; cyc(2);

        cur_req = "R7";
        chop_en = 1'b1; cyc(1);
        write_cfg(4'd0, 3'd1, 4'd0);
        sig_in = 1'b1; cyc(150);
        sig_in = 1'b0; cyc(2);
        chop_en = 1'b0; cyc(1);
        write_cfg(4'd0, 3'd1, 4'd0);
        chop_en = 1'b1; cyc(1);
        sig_in = 1'b1; cyc(60);
        sig_in = 1'b0; cyc(3);

        cur_req = "R1";
        rst = 1'b1; cyc(3);
        rst = 1'b0; chop_en = 1'b1; sig_in = 1'b1; cyc(30);
        sig_in = 1'b0; cyc(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(2.0 * HALF * MAX_CYC);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule